// File: doc/BRIEF.md
# Controller Serial I/O Port

This block is the controller end of a three-wire synchronous serial link. A 4-bit shift register sits between a serial input pin and a serial output pin. A gated clock output paces the peripherals on the link. The block counts system clocks to form its own instruction cycle of `CYC_CLKS` clocks, split into a first half and a second half. Each instruction cycle moves one bit of serial data, or advances the register by one when counter mode is selected.

The host uses a single exchange command. In one clock the command swaps a 4-bit word with the register and loads the clock-enable latch from a carry flag. The latch is the only thing that starts or stops the serial clock. While the latch is set and shift mode is active, the clock pin pulses once per instruction cycle. Counter mode holds the pin high, and returning to shift mode restarts the pulses at once without a new exchange. To keep the bit stream unbroken, the host exchanges once every four instruction cycles: it takes four received bits and gives four bits to send.

`CYC_CLKS` must be even and at least 4.

Top module: `sio_port`

## Requirements
- R1: In shift mode (`en_count`=0), at the edge that opens each instruction cycle the register moves one place toward its most significant end, and the level on `si` enters bit 0.
- R2: `so` is forced low whenever `en_out` is 0. When `en_out` is 1, `so` shows the register's bit 3 as held by the output stage.
- R3: The exchange command loads the register from `xchg_acc` one clock after `xchg_valid`. In the same clock, `xchg_rdata` takes the register's old value, the clock latch takes `xchg_carry`, and `so` shows the new bit 3.
- R4: While the clock latch is clear, `sk` is low in every mode and phase.
- R5: While the latch is set in shift mode, `sk` is high during the first `CYC_CLKS/2` clocks of each instruction cycle and low during the second half.
- R6: While the latch is set in counter mode, `sk` stays high. Returning to shift mode resumes the R5 pulses at once, with no exchange in between.
- R7: Outside an exchange, the output stage for `so` changes only at the middle of an instruction cycle. A shift at the start of a cycle does not show on `so` until that cycle's midpoint.
- R8: In counter mode (`en_count`=1) the register increases by one at the start of each instruction cycle, and 15 is followed by 0.
- R9: After reset the register, `xchg_rdata` and the latch are zero, and `sk` and `so` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xchg_valid | input | 1 | One-clock exchange command |
| xchg_carry | input | 1 | Carry flag loaded into the clock latch on exchange |
| xchg_acc | input | 4 | Word written into the register on exchange |
| en_count | input | 1 | 1 selects counter mode, 0 selects shift mode |
| en_out | input | 1 | 1 lets bit 3 drive `so` |
| si | input | 1 | Serial data in |
| sk | output | 1 | Gated serial clock |
| so | output | 1 | Serial data out |
| xchg_rdata | output | 4 | Register value returned by the last exchange |

## Verification
The bench targets four timing errors. A design that moves `so` at the start of a cycle instead of the midpoint would change the data while the peripheral samples it, so the bench checks `so` right after each shift edge. If a mode change did not reread the latch, `sk` would stay high after a return from counter mode or stay parked low, so the bench switches modes with the latch set. The bench steps the counter through 15 to 0 to catch a missing wrap. It runs four-cycle exchange frames, where a dropped or doubled shift would show up as a wrong nibble in the returned data.

// File: rtl/sio_pkg.sv
`timescale 1ns/1ps
package sio_pkg;
  parameter int SIO_W = 4;
  typedef logic [SIO_W-1:0] sio_word_t;

  // Shift-mode next value: toward the MSB, new bit at position 0.
  function automatic sio_word_t shift_in(input sio_word_t r, input logic b);
    return {r[SIO_W-2:0], b};
  endfunction

  // Counter-mode next value: modulo 2**SIO_W.
  function automatic sio_word_t count_up(input sio_word_t r);
    return r + sio_word_t'(1);
  endfunction
endpackage

// File: rtl/sio_phase.sv
`timescale 1ns/1ps
module sio_phase #(
  parameter int CYC_CLKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_start,
  output logic tick_mid,
  output logic first_half
);
  localparam int HALF = CYC_CLKS / 2;
  localparam int PW   = (CYC_CLKS > 2) ? $clog2(CYC_CLKS) : 1;
  localparam logic [PW-1:0] LAST = PW'(CYC_CLKS - 1);
  localparam logic [PW-1:0] MIDM = PW'(HALF - 1);
  localparam logic [PW-1:0] HALFV = PW'(HALF);

  logic [PW-1:0] ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ph <= '0;
    else if (ph == LAST)   ph <= '0;
    else                   ph <= ph + PW'(1);
  end

  assign tick_start = (ph == LAST);
  assign tick_mid   = (ph == MIDM);
  assign first_half = (ph < HALFV);

  assert_start_opens_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_start |=> first_half);
  assert_mid_closes_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_mid |=> !first_half);
endmodule

// File: rtl/sio_skgate.sv
`timescale 1ns/1ps
module sio_skgate (
  input  logic clk,
  input  logic rst_n,
  input  logic xchg_valid,
  input  logic xchg_carry,
  input  logic en_count,
  input  logic first_half,
  output logic sk
);
  logic sk_latch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sk_latch <= 1'b0;
    else if (xchg_valid) sk_latch <= xchg_carry;
  end

  assign sk = sk_latch & (en_count | first_half);

  assert_latch_clear_sk_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sk_latch |-> !sk);
  assert_count_mode_sk_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sk_latch && en_count) |-> sk);
  assert_latch_from_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xchg_valid |=> (sk_latch == $past(xchg_carry)));
endmodule

// File: rtl/sio_shreg.sv
`timescale 1ns/1ps
module sio_shreg
  import sio_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick_start,
  input  logic      tick_mid,
  input  logic      xchg_valid,
  input  sio_word_t xchg_acc,
  input  logic      en_count,
  input  logic      si,
  output sio_word_t rdata,
  output logic      so_q
);
  sio_word_t shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      rdata <= '0;
      so_q  <= 1'b0;
    end else if (xchg_valid) begin
      shreg <= xchg_acc;
      rdata <= shreg;
      so_q  <= xchg_acc[SIO_W-1];
    end else begin
      if (tick_start) shreg <= en_count ? count_up(shreg) : shift_in(shreg, si);
      if (tick_mid)   so_q  <= shreg[SIO_W-1];
    end
  end

  assert_shift_takes_si_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_start && !xchg_valid && !en_count) |=>
      (shreg[0] == $past(si)) && (shreg[SIO_W-1:1] == $past(shreg[SIO_W-2:0])));
  assert_count_wraps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_start && !xchg_valid && en_count) |=>
      (shreg == sio_word_t'($past(shreg) + 1)));
  assert_exchange_swap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xchg_valid |=> (shreg == $past(xchg_acc)) && (rdata == $past(shreg)));
  assert_so_moves_mid_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_mid && !xchg_valid) |=> $stable(so_q));
endmodule

// File: rtl/sio_port.sv
`timescale 1ns/1ps
module sio_port
  import sio_pkg::*;
#(
  parameter int CYC_CLKS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xchg_valid,
  input  logic             xchg_carry,
  input  logic [SIO_W-1:0] xchg_acc,
  input  logic             en_count,
  input  logic             en_out,
  input  logic             si,
  output logic             sk,
  output logic             so,
  output logic [SIO_W-1:0] xchg_rdata
);
  logic tick_start, tick_mid, first_half, so_q;

  sio_phase #(.CYC_CLKS(CYC_CLKS)) u_phase (
    .clk(clk), .rst_n(rst_n),
    .tick_start(tick_start), .tick_mid(tick_mid), .first_half(first_half)
  );

  sio_skgate u_skgate (
    .clk(clk), .rst_n(rst_n),
    .xchg_valid(xchg_valid), .xchg_carry(xchg_carry),
    .en_count(en_count), .first_half(first_half), .sk(sk)
  );

  sio_shreg u_shreg (
    .clk(clk), .rst_n(rst_n),
    .tick_start(tick_start), .tick_mid(tick_mid),
    .xchg_valid(xchg_valid), .xchg_acc(xchg_acc),
    .en_count(en_count), .si(si),
    .rdata(xchg_rdata), .so_q(so_q)
  );

  assign so = so_q & en_out;

  assert_so_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_out |-> !so);
endmodule

// File: tb/sim_sio_port.sv
`timescale 1ns/1ps
module sim_sio_port;
  localparam int CYC  = 8;
  localparam int HALF = CYC / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xchg_valid = 1'b0, xchg_carry = 1'b0, en_count = 1'b0, en_out = 1'b0, si = 1'b0;
  logic [3:0] xchg_acc = '0;
  logic sk, so;
  logic [3:0] xchg_rdata;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [3:0] m_reg = '0, m_rd = '0;
  logic m_latch = 1'b0, m_so = 1'b0;

  always #2.5 clk = ~clk;

  sio_port #(.CYC_CLKS(CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .xchg_valid(xchg_valid), .xchg_carry(xchg_carry),
    .xchg_acc(xchg_acc), .en_count(en_count), .en_out(en_out), .si(si),
    .sk(sk), .so(so), .xchg_rdata(xchg_rdata)
  );

  function automatic logic [3:0] ref_shift(input logic [3:0] r, input logic b);
    logic [3:0] t;
    t = r << 1;
    t[0] = b;
    return t;
  endfunction

  function automatic logic [3:0] ref_count(input logic [3:0] r);
    return (r == 4'd15) ? 4'd0 : r + 4'd1;
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Entered at a negedge in phase 0; leaves at a negedge in phase 0 of the next cycle.
  task automatic icycle(input logic x, input logic c, input logic [3:0] a,
                        input logic s, input logic e0, input logic e3);
    en_count = e0;
    en_out   = e3;
    #1;
    chk(m_latch ? "R5 sk first half" : "R4 sk low", {3'b0, sk}, {3'b0, m_latch});
    chk("R7 so holds until mid", {3'b0, so}, {3'b0, e3 & m_so});
    repeat (HALF) @(posedge clk);
    @(negedge clk);
    m_so = m_reg[3];
    chk(e3 ? "R7 so at mid" : "R2 so gated", {3'b0, so}, {3'b0, e3 & m_so});
    chk(e0 ? "R6 sk count mode" : "R5 sk second half", {3'b0, sk}, {3'b0, m_latch & e0});
    si = s;
    if (x) begin
      xchg_valid = 1'b1; xchg_carry = c; xchg_acc = a;
      @(posedge clk);
      @(negedge clk);
      xchg_valid = 1'b0;
      m_rd = m_reg; m_reg = a; m_latch = c; m_so = a[3];
      chk("R3 rdata", xchg_rdata, m_rd);
      chk("R3 so new bit3", {3'b0, so}, {3'b0, e3 & m_so});
      chk("R4 sk after exchange", {3'b0, sk}, {3'b0, c & e0});
      repeat (HALF - 1) @(posedge clk);
    end else begin
      repeat (HALF) @(posedge clk);
    end
    m_reg = e0 ? ref_count(m_reg) : ref_shift(m_reg, s);
    @(negedge clk);
  endtask

  initial begin
    repeat (CYC * 50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R9 sk reset", {3'b0, sk}, 4'd0);
    chk("R9 so reset", {3'b0, so}, 4'd0);
    chk("R9 rdata reset", xchg_rdata, 4'd0);
    rst_n = 1'b1;

    // R1/R3: four-cycle frame, load 1010, shift in 0110, read back.
    icycle(1, 1, 4'b1010, 0, 0, 1);
    icycle(0, 0, 0, 1, 0, 1);
    icycle(0, 0, 0, 1, 0, 1);
    icycle(0, 0, 0, 0, 0, 1);
    icycle(1, 1, 4'b0101, 1, 0, 1);
    chk("R1 frame readback", xchg_rdata, 4'b0110);
    // R2: output disabled
    icycle(0, 0, 0, 1, 0, 0);
    icycle(0, 0, 0, 0, 0, 0);
    // R8/R6: counter wrap with latch set, then back to shift mode
    icycle(1, 1, 4'hE, 0, 1, 1);
    icycle(0, 0, 0, 0, 1, 1);
    icycle(0, 0, 0, 0, 1, 1);
    icycle(0, 0, 0, 1, 0, 1);
    icycle(1, 1, 4'h0, 0, 0, 1);
    chk("R8 wrap readback", xchg_rdata, 4'b0011);
    // R4: stop the clock
    icycle(1, 0, 4'h9, 1, 0, 1);
    icycle(0, 0, 0, 0, 1, 1);
    icycle(0, 0, 0, 1, 0, 1);

    for (int i = 0; i < 300; i++) begin
      logic x, e0, e3;
      x  = ($urandom % 4) == 0;
      e0 = ($urandom % 5) == 0;
      e3 = ($urandom % 6) != 0;
      icycle(x, 1'($urandom), 4'($urandom), 1'($urandom), e0, e3);
    end
    icycle(1, 0, 4'h0, 0, 0, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule